// File: doc/BRIEF.md
# Scaler Channel Gate Qualifier

This block decides, cycle by cycle, whether one scaler channel counts. It combines three kinds of source: a shared gate signal common to all channels, a timing strobe, and six individual control signals that belong to this chip. Each individual signal can be inverted and enabled on its own. The enabled individual signals are reduced to one group term, either by AND or by NAND. The common term, the strobe term and the group term are then ANDed together under an overall enable. The result drives the channel counter's count qualifier.

A 16-bit control register holds all of these choices. A second, 1-bit chaining register lets a channel ignore its own sources. The gate then becomes the previous channel's carry-out ANDed with the previous channel's gate, so two counters can act as one wider counter. The first channel has no predecessor and is built without this option. The same module, also built without chaining, produces the channel's load qualifier. Both registers clear on reset, so the channel stays idle until it is programmed.

Top module: `gate_qual`

## Requirements
- R1: After reset both registers hold zero and `qual_out` is 0 whatever the source inputs are.
- R2: When control bit 15 (overall enable) is 0 and chaining is off, `qual_out` is 0.
- R3: A control value with only bit 15 set gives `qual_out` = 1 for every input pattern.
- R4: Control bit 0 adds `common_in` as a term. When bit 0 is clear, `common_in` has no effect.
- R5: Control bit 1 adds `strobe_in` as a term. When bit 1 is clear, `strobe_in` has no effect.
- R6: For individual signal k (0..5), control bit 3+2k enables `ics_in[k]` and bit 2+2k inverts it. A disabled signal has no effect.
- R7: Control bit 14 = 0 makes the group term the AND of the enabled (possibly inverted) individual signals; with none enabled it is 1. Bit 14 = 1 makes it the NAND. Inverting every enabled signal under NAND therefore gives their OR. NAND with none enabled gives 0.
- R8: With bit 15 set, `qual_out` is the AND of the common term, the strobe term and the group term.
- R9: With HAS_CHAIN = 1 and the chaining bit (bit 0 of the chain register) set, `qual_out` equals `prev_carry AND prev_gate`, regardless of the control register.
- R10: With HAS_CHAIN = 0, chain-register writes and the `prev_carry`/`prev_gate` inputs have no effect on `qual_out`.
- R11: A register write presented with its write enable at a rising clock edge changes `qual_out` from that edge on. Without a write enable the registers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Write enable for the control register |
| ctl_wdata | input | 16 | Control register write value |
| chain_we | input | 1 | Write enable for the chaining register |
| chain_wdata | input | 1 | Chaining register write value |
| common_in | input | 1 | Shared common gate |
| strobe_in | input | 1 | Timing strobe |
| ics_in | input | 6 | Individual control signals |
| prev_carry | input | 1 | Previous channel carry-out |
| prev_gate | input | 1 | Previous channel gate |
| qual_out | output | 1 | Channel qualifier to the counter |

## Verification
The assertions check on every cycle that the registers clear on reset and then follow their write enables. They also check that a cleared overall enable holds the qualifier low, that the bit-15-only value holds it high, and that chaining passes the predecessor's carry and gate straight through. Only the bench's scenarios show how the sources actually combine: the single-source tracking, invert and enable of each individual signal, the OR obtained through NAND, and the three-way AND. The bench also shows the cycle on which a write first takes effect, and that a build without chaining ignores chain writes and predecessor inputs.

// File: rtl/gate_qual.sv
module gate_qual #(
  parameter int NUM_ICS   = 6,
  parameter bit HAS_CHAIN = 1'b1,
  localparam int CTL_W    = 2 * NUM_ICS + 4,
  localparam int GRP_BIT  = CTL_W - 2,
  localparam int ENA_BIT  = CTL_W - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_we,
  input  logic [CTL_W-1:0]   ctl_wdata,
  input  logic               chain_we,
  input  logic               chain_wdata,
  input  logic               common_in,
  input  logic               strobe_in,
  input  logic [NUM_ICS-1:0] ics_in,
  input  logic               prev_carry,
  input  logic               prev_gate,
  output logic               qual_out
);

  logic [CTL_W-1:0]   ctl_q;
  logic               chain_q;
  logic [NUM_ICS-1:0] ics_term;
  logic               grp_and, grp_term, com_term, stb_term, own_gate;

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_wdata;
  end

  for (genvar k = 0; k < NUM_ICS; k++) begin : g_ics
    assign ics_term[k] = !ctl_q[3+2*k] || (ics_in[k] ^ ctl_q[2+2*k]);
  end

  assign grp_and  = &ics_term;
  assign grp_term = ctl_q[GRP_BIT] ? !grp_and : grp_and;
  assign com_term = !ctl_q[0] || common_in;
  assign stb_term = !ctl_q[1] || strobe_in;
  assign own_gate = ctl_q[ENA_BIT] && com_term && stb_term && grp_term;

  if (HAS_CHAIN) begin : g_chain
    always_ff @(posedge clk) begin
      if (!rst_n)        chain_q <= 1'b0;
      else if (chain_we) chain_q <= chain_wdata;
    end
    assign qual_out = chain_q ? (prev_carry && prev_gate) : own_gate;
  end else begin : g_nochain
    logic unused_chain;
    assign unused_chain = &{1'b0, chain_we, chain_wdata, prev_carry, prev_gate};
    assign chain_q  = 1'b0;
    assign qual_out = own_gate;
  end

endmodule

module gate_qual_chk #(
  parameter int CTL_W     = 16,
  parameter bit HAS_CHAIN = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic [CTL_W-1:0] ctl_wdata,
  input logic [CTL_W-1:0] ctl_q,
  input logic             chain_q,
  input logic             prev_carry,
  input logic             prev_gate,
  input logic             qual_out
);
  localparam logic [CTL_W-1:0] ONLY_ENA = {1'b1, {(CTL_W-1){1'b0}}};

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (ctl_q == '0 && !chain_q && !qual_out)); // R1
  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[CTL_W-1] && !chain_q) |-> !qual_out); // R2
  AST_FORCED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q == ONLY_ENA && !chain_q) |-> qual_out); // R3
  AST_CHAIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_CHAIN && chain_q) |-> (qual_out == (prev_carry && prev_gate))); // R9
  AST_NOCHAIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!HAS_CHAIN && !ctl_q[CTL_W-1]) |-> !qual_out); // R10
  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl_q == $past(ctl_wdata))); // R11
  AST_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_we && $past(rst_n)) |=> $stable(ctl_q)); // R11
endmodule

bind gate_qual gate_qual_chk #(.CTL_W(CTL_W), .HAS_CHAIN(HAS_CHAIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .ctl_q(ctl_q), .chain_q(chain_q), .prev_carry(prev_carry),
  .prev_gate(prev_gate), .qual_out(qual_out)
);

// File: tb/sim_gate_qual.sv
`timescale 1ns/1ps
module sim_gate_qual;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic        chain_we = 1'b0;
  logic        chain_wdata = 1'b0;
  logic        common_in = 1'b0;
  logic        strobe_in = 1'b0;
  logic [5:0]  ics_in = '0;
  logic        prev_carry = 1'b0;
  logic        prev_gate = 1'b0;
  logic        q0, q1;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gate_qual #(.HAS_CHAIN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .chain_we(chain_we), .chain_wdata(chain_wdata), .common_in(common_in),
    .strobe_in(strobe_in), .ics_in(ics_in), .prev_carry(prev_carry),
    .prev_gate(prev_gate), .qual_out(q0));

  gate_qual #(.HAS_CHAIN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .chain_we(chain_we), .chain_wdata(chain_wdata), .common_in(common_in),
    .strobe_in(strobe_in), .ics_in(ics_in), .prev_carry(prev_carry),
    .prev_gate(prev_gate), .qual_out(q1));

  task automatic check(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic wr_ctl(input logic [15:0] d);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_chain(input logic d);
    @(negedge clk); chain_we = 1'b1; chain_wdata = d;
    @(negedge clk); chain_we = 1'b0;
  endtask

  task automatic drive(input logic c, input logic s, input logic [5:0] i);
    common_in = c; strobe_in = s; ics_in = i; #1;
  endtask

  task automatic t_reset;
    drive(1, 1, 6'h3F); prev_carry = 1; prev_gate = 1; #1;
    check(q0, 0, "R1 reset u0 all high");
    check(q1, 0, "R1 reset u1 all high");
    drive(0, 0, 6'h00);
    check(q0, 0, "R1 reset u0 all low");
    prev_carry = 0; prev_gate = 0;
  endtask

  task automatic t_force_high;
    wr_ctl(16'h8000);
    drive(0, 0, 6'h00); check(q0, 1, "R3 only enable, inputs low");
    drive(1, 0, 6'h2A); check(q0, 1, "R3 only enable, mixed inputs");
    drive(1, 1, 6'h3F); check(q1, 1, "R3 only enable, u1");
  endtask

  task automatic t_disabled;
    wr_ctl(16'h7FFF);
    drive(1, 1, 6'h00); check(q0, 0, "R2 overall enable clear");
    drive(1, 1, 6'h3F); check(q0, 0, "R2 overall enable clear, ics high");
  endtask

  task automatic t_common;
    wr_ctl(16'h8001);
    drive(0, 1, 6'h3F); check(q0, 0, "R4 common low");
    drive(1, 0, 6'h00); check(q0, 1, "R4 common high");
    wr_ctl(16'h8000);
    drive(0, 0, 6'h00); check(q0, 1, "R4 common disabled ignored");
  endtask

  task automatic t_strobe;
    wr_ctl(16'h8002);
    drive(1, 0, 6'h3F); check(q0, 0, "R5 strobe low");
    drive(0, 1, 6'h00); check(q0, 1, "R5 strobe high");
  endtask

  task automatic t_ics;
    wr_ctl(16'h8080);
    drive(0, 0, 6'h04); check(q0, 1, "R6 ics2 enabled high");
    drive(0, 0, 6'h3B); check(q0, 0, "R6 ics2 enabled low, others ignored");
    wr_ctl(16'h80C0);
    drive(0, 0, 6'h3B); check(q0, 1, "R6 ics2 inverted low");
    drive(0, 0, 6'h04); check(q0, 0, "R6 ics2 inverted high");
    wr_ctl(16'hB000);
    drive(0, 0, 6'h1F); check(q0, 1, "R6 ics5 inverted low");
    drive(0, 0, 6'h20); check(q0, 0, "R6 ics5 inverted high");
  endtask

  task automatic t_nand;
    wr_ctl(16'hC03C);
    drive(0, 0, 6'h00); check(q0, 0, "R7 or of ics0/1 both low");
    drive(0, 0, 6'h01); check(q0, 1, "R7 or, ics0 high");
    drive(0, 0, 6'h02); check(q0, 1, "R7 or, ics1 high");
    drive(0, 0, 6'h03); check(q0, 1, "R7 or, both high");
    wr_ctl(16'hC000);
    drive(1, 1, 6'h3F); check(q0, 0, "R7 nand with no enabled signals");
  endtask

  task automatic t_and;
    wr_ctl(16'h800B);
    drive(1, 1, 6'h01); check(q0, 1, "R8 all three terms high");
    drive(0, 1, 6'h01); check(q0, 0, "R8 common term low");
    drive(1, 0, 6'h01); check(q0, 0, "R8 strobe term low");
    drive(1, 1, 6'h3E); check(q0, 0, "R8 group term low");
  endtask

  task automatic t_chain;
    wr_ctl(16'h0000);
    wr_chain(1'b1);
    drive(0, 0, 6'h00);
    prev_carry = 1; prev_gate = 1; #1;
    check(q0, 1, "R9 chain carry and gate high");
    check(q1, 0, "R10 no-chain build ignores predecessor");
    prev_gate = 0; #1;
    check(q0, 0, "R9 chain gate low");
    prev_carry = 0; prev_gate = 1; #1;
    check(q0, 0, "R9 chain carry low");
    wr_ctl(16'h8000);
    prev_carry = 0; prev_gate = 0; #1;
    check(q0, 0, "R9 chain overrides forced high");
    check(q1, 1, "R10 no-chain build keeps own gate");
    wr_chain(1'b0);
    check(q0, 1, "R9 chain cleared restores own gate");
  endtask

  task automatic t_timing;
    wr_ctl(16'h0000);
    drive(0, 0, 6'h00);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = 16'h8000; #1;
    check(q0, 0, "R11 no change before edge");
    @(negedge clk); ctl_we = 1'b0; ctl_wdata = 16'h0000; #1;
    check(q0, 1, "R11 change after edge");
    @(negedge clk); @(negedge clk); #1;
    check(q0, 1, "R11 hold without write enable");
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_force_high();
    t_disabled();
    t_common();
    t_strobe();
    t_ics();
    t_nand();
    t_and();
    t_chain();
    t_timing();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end
endmodule